// File: doc/BRIEF.md
# Upstream Port Reset and Suspend Detector

This block sits on the upstream-facing port of a bus device and decides, from the decoded line state, whether the host is resetting the device, suspending it, or waking it. The surrounding device logic tells it which of three operating contexts it is in: suspended, operating at full speed, or operating at high speed. Each context has its own detection path. A suspended device first waits for its clock to settle and then filters SE0. A full-speed device times an unchanged SE0 or idle. A high-speed device times high-speed idle, falls back to full-speed terminations, waits for the line to settle, and then samples the line once more.

The decision is reported as a single-cycle pulse: start the reset handshake, enter suspend, start resume, or abandon detection and keep the previous state. The block also owns the termination control (high-speed terminations and the D+ pull-up). Its master timer keeps running after a handshake start and is exported, so a separate handshake engine can share the same time base. All durations are parameters in clock cycles. There is no streaming data path, so every pin is a plain level or pulse with no handshake.

Top module: `usbd_rst_detect`

## Requirements
Edge 0 below is the first rising clock edge at which the detector sees the line state that starts detection. "At edge n" means the output has its new value just after edge n. Parameter names are those of the top module.
- R1: While rst_n is low and just after it is released, hs_term_en is 0, dp_pullup_en is 1, all four result pulses are 0 and t0_count is 0.
- R2: hsk_start, susp_enter, resume_start and detect_abort are single-cycle pulses, and at most one of them is high in any cycle.
- R3: line is one-hot with bit 0 = SE0, bit 1 = J (full-speed idle), bit 2 = K. With ctx = 0 (suspended), K gives resume_start at edge 0; J is ignored: no pulse and t0_count stays 0.
- R4: With ctx = 0, SE0 starts the master timer. SE0 is not examined until the timer reaches WTCLK_CYC; after that, SE0 present for FILTSE0_CYC+1 consecutive edges gives hsk_start, i.e. at edge WTCLK_CYC+FILTSE0_CYC+2 for steady SE0. A missing SE0 during the settle wait has no effect; a missing SE0 at edge g during filtering restarts the filter, moving hsk_start to edge g+FILTSE0_CYC+1.
- R5: With ctx = 0, if the filter has not completed when the master timer reaches UCHWIN_CYC, susp_enter fires at edge UCHWIN_CYC+1.
- R6: With ctx = 1 (full speed), J held unchanged gives susp_enter at edge FSSUSP_CYC+1; SE0 held unchanged gives hsk_start at edge WTRSTFS_CYC+1. K starts nothing.
- R7: With ctx = 1, a line value different from the one that started detection, first seen at edge d before the outcome, gives detect_abort at edge d and no other pulse.
- R8: With ctx = 2 (high speed) and hs_idle high, hs_term_en goes to 1 and dp_pullup_en to 0 at edge 0. If hs_idle stays high through edge WTREV_CYC+1, at that edge hs_term_en returns to 0 and dp_pullup_en to 1; if hs_idle is first seen low at an earlier edge d, detect_abort fires at edge d.
- R9: After the high-speed fallback, the line is sampled at edge WTREV_CYC+WTRSTHS_CYC+2: SE0 gives hsk_start; J or K gives susp_enter. hs_idle is ignored after the fallback.
- R10: After hsk_start, susp_enter or resume_start, the line and hs_idle are ignored until ctx differs from its value at the outcome, and t0_count keeps counting up by one per cycle from 0 at edge 0 (saturating).
- R11: ctx = 3 means no context: nothing is detected, no pulse fires and t0_count stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctx | input | 2 | Operating context: 0 suspended, 1 full speed, 2 high speed, 3 none |
| line | input | 3 | One-hot decoded full-speed line state: bit 0 SE0, bit 1 J, bit 2 K |
| hs_idle | input | 1 | High-speed idle seen on the bus |
| hs_term_en | output | 1 | High-speed terminations enabled |
| dp_pullup_en | output | 1 | D+ pull-up connected |
| hsk_start | output | 1 | Pulse: begin the reset handshake |
| susp_enter | output | 1 | Pulse: enter suspend |
| resume_start | output | 1 | Pulse: begin resume |
| detect_abort | output | 1 | Pulse: detection abandoned, keep previous state |
| t0_count | output | T0_W | Master timer value, shared with the handshake engine |

## Verification
The assertions take for granted that line is always exactly one-hot once reset is released and that the inputs are already synchronous to clk; one of them checks the one-hot rule outright. They also assume the context only moves to a new value after an outcome, never in the middle of a timed detection. The stimulus drives all inputs on the falling edge, always picks a line value from the three legal codes, and parks the block in context 3 between cases, so every case starts from a clean watch state.

// File: rtl/usbd_rsd_pkg.sv
package usbd_rsd_pkg;

  typedef enum logic [1:0] {
    CTX_SUSP = 2'd0,
    CTX_FS   = 2'd1,
    CTX_HS   = 2'd2,
    CTX_NONE = 2'd3
  } ctx_e;

  typedef enum logic [3:0] {
    ST_WATCH,
    ST_SETTLE,
    ST_FILT,
    ST_FS_IDLE,
    ST_FS_SE0,
    ST_HS_IDLE,
    ST_HS_SETTLE,
    ST_PARK
  } rsd_state_e;

  localparam int LINE_SE0 = 0;
  localparam int LINE_J   = 1;
  localparam int LINE_K   = 2;
  localparam int LINE_W   = 3;

endpackage

// File: rtl/usbd_rsd_line_dec.sv
module usbd_rsd_line_dec
  import usbd_rsd_pkg::*;
(
  input  logic [LINE_W-1:0] line,
  output logic              se0,
  output logic              jst,
  output logic              kst
);

  // Each flag requires its own bit and no other, so an illegal code reads as nothing.
  always_comb begin
    se0 = (line == LINE_W'(1 << LINE_SE0));
    jst = (line == LINE_W'(1 << LINE_J));
    kst = (line == LINE_W'(1 << LINE_K));
  end

endmodule

// File: rtl/usbd_rsd_timer.sv
module usbd_rsd_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] CMAX = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (run && (count != CMAX)) begin
      count <= count + W'(1);
    end
  end

endmodule

// File: rtl/usbd_rsd_fsm.sv
module usbd_rsd_fsm
  import usbd_rsd_pkg::*;
#(
  parameter int unsigned T0_W        = 20,
  parameter int unsigned T1_W        = 16,
  parameter int unsigned WTCLK_CYC   = 60000,
  parameter int unsigned FILTSE0_CYC = 150,
  parameter int unsigned UCHWIN_CYC  = 360000,
  parameter int unsigned FSSUSP_CYC  = 180000,
  parameter int unsigned WTRSTFS_CYC = 6000,
  parameter int unsigned WTREV_CYC   = 183750,
  parameter int unsigned WTRSTHS_CYC = 6000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ctx,
  input  logic [LINE_W-1:0] line,
  input  logic              se0,
  input  logic              jst,
  input  logic              kst,
  input  logic              hs_idle,
  input  logic [T0_W-1:0]   t0,
  input  logic [T1_W-1:0]   t1,
  output logic              t0_clr,
  output logic              t0_run,
  output logic              t1_clr,
  output logic              t1_run,
  output logic              hs_term_q,
  output logic              hsk_q,
  output logic              susp_q,
  output logic              res_q,
  output logic              abt_q
);

  localparam logic [T0_W-1:0] LIM_WTCLK   = T0_W'(WTCLK_CYC);
  localparam logic [T0_W-1:0] LIM_UCHWIN  = T0_W'(UCHWIN_CYC);
  localparam logic [T0_W-1:0] LIM_FSSUSP  = T0_W'(FSSUSP_CYC);
  localparam logic [T0_W-1:0] LIM_WTRSTFS = T0_W'(WTRSTFS_CYC);
  localparam logic [T0_W-1:0] LIM_WTREV   = T0_W'(WTREV_CYC);
  localparam logic [T1_W-1:0] LIM_FILT    = T1_W'(FILTSE0_CYC);
  localparam logic [T1_W-1:0] LIM_WTRSTHS = T1_W'(WTRSTHS_CYC);

  rsd_state_e        st_q, st_d;
  ctx_e              ctx_in;
  logic [1:0]        ctx_q;
  logic [LINE_W-1:0] line_q;
  logic              fire_hsk, fire_susp, fire_res, fire_abt;
  logic              term_d, line_ld, park_ld;

  assign ctx_in = ctx_e'(ctx);

  // Master timer: held at zero while watching, free running in every other state.
  assign t0_clr  = (st_q == ST_WATCH);
  assign t0_run  = 1'b1;
  assign park_ld = (st_d == ST_PARK) && (st_q != ST_PARK);

  always_comb begin
    st_d      = st_q;
    fire_hsk  = 1'b0;
    fire_susp = 1'b0;
    fire_res  = 1'b0;
    fire_abt  = 1'b0;
    term_d    = hs_term_q;
    t1_clr    = 1'b0;
    t1_run    = 1'b0;
    line_ld   = 1'b0;
    unique case (st_q)
      ST_WATCH: begin
        term_d = (ctx_in == CTX_HS);
        unique case (ctx_in)
          CTX_SUSP: begin
            if (kst) begin
              fire_res = 1'b1;
              st_d     = ST_PARK;
            end else if (se0) begin
              st_d = ST_SETTLE;
            end
          end
          CTX_FS: begin
            line_ld = 1'b1;
            if (se0) st_d = ST_FS_SE0;
            else if (jst) st_d = ST_FS_IDLE;
          end
          CTX_HS: begin
            if (hs_idle) st_d = ST_HS_IDLE;
          end
          default: st_d = ST_WATCH;
        endcase
      end
      ST_SETTLE: begin
        if (t0 >= LIM_WTCLK) begin
          t1_clr = 1'b1;
          st_d   = ST_FILT;
        end
      end
      ST_FILT: begin
        t1_clr = !se0;
        t1_run = se0;
        if (t1 >= LIM_FILT) begin
          fire_hsk = 1'b1;
          st_d     = ST_PARK;
        end else if (t0 >= LIM_UCHWIN) begin
          fire_susp = 1'b1;
          st_d      = ST_PARK;
        end
      end
      ST_FS_IDLE: begin
        if (line != line_q) begin
          fire_abt = 1'b1;
          st_d     = ST_WATCH;
        end else if (t0 >= LIM_FSSUSP) begin
          fire_susp = 1'b1;
          st_d      = ST_PARK;
        end
      end
      ST_FS_SE0: begin
        if (line != line_q) begin
          fire_abt = 1'b1;
          st_d     = ST_WATCH;
        end else if (t0 >= LIM_WTRSTFS) begin
          fire_hsk = 1'b1;
          st_d     = ST_PARK;
        end
      end
      ST_HS_IDLE: begin
        if (!hs_idle) begin
          fire_abt = 1'b1;
          st_d     = ST_WATCH;
        end else if (t0 >= LIM_WTREV) begin
          term_d = 1'b0;
          t1_clr = 1'b1;
          st_d   = ST_HS_SETTLE;
        end
      end
      ST_HS_SETTLE: begin
        t1_run = 1'b1;
        if (t1 >= LIM_WTRSTHS) begin
          fire_hsk  = se0;
          fire_susp = !se0;
          st_d      = ST_PARK;
        end
      end
      ST_PARK: begin
        if (ctx != ctx_q) st_d = ST_WATCH;
      end
      default: st_d = ST_WATCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_WATCH;
      ctx_q     <= CTX_NONE;
      line_q    <= '0;
      hs_term_q <= 1'b0;
      hsk_q     <= 1'b0;
      susp_q    <= 1'b0;
      res_q     <= 1'b0;
      abt_q     <= 1'b0;
    end else begin
      st_q      <= st_d;
      hs_term_q <= term_d;
      hsk_q     <= fire_hsk;
      susp_q    <= fire_susp;
      res_q     <= fire_res;
      abt_q     <= fire_abt;
      if (park_ld) ctx_q <= ctx;
      if (line_ld) line_q <= line;
    end
  end

endmodule

// File: rtl/usbd_rst_detect.sv
module usbd_rst_detect
  import usbd_rsd_pkg::*;
#(
  parameter int unsigned T0_W        = 20,
  parameter int unsigned T1_W        = 16,
  parameter int unsigned WTCLK_CYC   = 60000,
  parameter int unsigned FILTSE0_CYC = 150,
  parameter int unsigned UCHWIN_CYC  = 360000,
  parameter int unsigned FSSUSP_CYC  = 180000,
  parameter int unsigned WTRSTFS_CYC = 6000,
  parameter int unsigned WTREV_CYC   = 183750,
  parameter int unsigned WTRSTHS_CYC = 6000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      ctx,
  input  logic [2:0]      line,
  input  logic            hs_idle,
  output logic            hs_term_en,
  output logic            dp_pullup_en,
  output logic            hsk_start,
  output logic            susp_enter,
  output logic            resume_start,
  output logic            detect_abort,
  output logic [T0_W-1:0] t0_count
);

  logic            se0, jst, kst;
  logic            t0_clr, t0_run, t1_clr, t1_run;
  logic [T1_W-1:0] t1_count;
  logic            hs_term_q;

  usbd_rsd_line_dec u_dec (
    .line (line),
    .se0  (se0),
    .jst  (jst),
    .kst  (kst)
  );

  usbd_rsd_timer #(.W(T0_W)) u_t0 (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (t0_clr),
    .run   (t0_run),
    .count (t0_count)
  );

  usbd_rsd_timer #(.W(T1_W)) u_t1 (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (t1_clr),
    .run   (t1_run),
    .count (t1_count)
  );

  usbd_rsd_fsm #(
    .T0_W        (T0_W),
    .T1_W        (T1_W),
    .WTCLK_CYC   (WTCLK_CYC),
    .FILTSE0_CYC (FILTSE0_CYC),
    .UCHWIN_CYC  (UCHWIN_CYC),
    .FSSUSP_CYC  (FSSUSP_CYC),
    .WTRSTFS_CYC (WTRSTFS_CYC),
    .WTREV_CYC   (WTREV_CYC),
    .WTRSTHS_CYC (WTRSTHS_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctx       (ctx),
    .line      (line),
    .se0       (se0),
    .jst       (jst),
    .kst       (kst),
    .hs_idle   (hs_idle),
    .t0        (t0_count),
    .t1        (t1_count),
    .t0_clr    (t0_clr),
    .t0_run    (t0_run),
    .t1_clr    (t1_clr),
    .t1_run    (t1_run),
    .hs_term_q (hs_term_q),
    .hsk_q     (hsk_start),
    .susp_q    (susp_enter),
    .res_q     (resume_start),
    .abt_q     (detect_abort)
  );

  assign hs_term_en   = hs_term_q;
  assign dp_pullup_en = !hs_term_q;

endmodule

// File: rtl/usbd_rst_detect_chk.sv
module usbd_rst_detect_chk #(
  parameter int unsigned T0_W = 20
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      ctx,
  input logic [2:0]      line,
  input logic            hs_idle,
  input logic            hs_term_en,
  input logic            hsk_start,
  input logic            susp_enter,
  input logic            resume_start,
  input logic            detect_abort,
  input logic [T0_W-1:0] t0_count
);

  logic [3:0] pulses;
  assign pulses = {detect_abort, resume_start, susp_enter, hsk_start};

  // Input assumption: the decoded line is always a legal one-hot code.
  p_line_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(line));

  p_pulse_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulses));

  p_pulse_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pulses != 4'b0) |=> (pulses == 4'b0));

  p_resume_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    resume_start |-> ($past(line) == 3'b100 && $past(ctx) == 2'd0));

  p_abort_ctx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    detect_abort |-> ($past(ctx) == 2'd1 || $past(ctx) == 2'd2));

  p_term_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_term_en) |-> ($past(ctx) == 2'd2 && $past(hs_idle)));

  p_t0_runs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hsk_start && (t0_count != {T0_W{1'b1}})) |=> (t0_count == $past(t0_count) + T0_W'(1)));

endmodule

bind usbd_rst_detect usbd_rst_detect_chk #(.T0_W(T0_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctx          (ctx),
  .line         (line),
  .hs_idle      (hs_idle),
  .hs_term_en   (hs_term_en),
  .hsk_start    (hsk_start),
  .susp_enter   (susp_enter),
  .resume_start (resume_start),
  .detect_abort (detect_abort),
  .t0_count     (t0_count)
);

// File: tb/sim_usbd_rst_detect.sv
module sim_usbd_rst_detect;

  localparam int CLK_PERIOD = 10;
  localparam int T0_W    = 8;
  localparam int T1_W    = 6;
  localparam int WTCLK   = 6;
  localparam int FILTSE0 = 4;
  localparam int UCHWIN  = 30;
  localparam int FSSUSP  = 25;
  localparam int WTRSTFS = 10;
  localparam int WTREV   = 20;
  localparam int WTRSTHS = 5;

  localparam logic [2:0] L_SE0 = 3'b001;
  localparam logic [2:0] L_J   = 3'b010;
  localparam logic [2:0] L_K   = 3'b100;
  localparam logic [1:0] C_SUSP = 2'd0, C_FS = 2'd1, C_HS = 2'd2, C_NONE = 2'd3;
  // Pulse vector {abort, resume, susp, hsk}
  localparam logic [3:0] P_HSK = 4'b0001, P_SUSP = 4'b0010, P_RES = 4'b0100, P_ABT = 4'b1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] ctx = C_NONE;
  logic [2:0] line = L_J;
  logic hs_idle = 1'b0;
  logic hs_term_en, dp_pullup_en, hsk_start, susp_enter, resume_start, detect_abort;
  logic [T0_W-1:0] t0_count;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usbd_rst_detect #(
    .T0_W(T0_W), .T1_W(T1_W), .WTCLK_CYC(WTCLK), .FILTSE0_CYC(FILTSE0),
    .UCHWIN_CYC(UCHWIN), .FSSUSP_CYC(FSSUSP), .WTRSTFS_CYC(WTRSTFS),
    .WTREV_CYC(WTREV), .WTRSTHS_CYC(WTRSTHS)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .ctx(ctx), .line(line), .hs_idle(hs_idle),
    .hs_term_en(hs_term_en), .dp_pullup_en(dp_pullup_en), .hsk_start(hsk_start),
    .susp_enter(susp_enter), .resume_start(resume_start), .detect_abort(detect_abort),
    .t0_count(t0_count)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(output logic [3:0] p);
    @(posedge clk);
    @(negedge clk);
    p = {detect_abort, resume_start, susp_enter, hsk_start};
  endtask

  task automatic neutral();
    logic [3:0] p;
    ctx = C_NONE; line = L_J; hs_idle = 1'b0;
    repeat (3) step(p);
  endtask

  function automatic int fs_edge(input int lim, input int d);
    return (d >= lim + 2) ? lim + 1 : d;
  endfunction

  function automatic int susp_edge(input int mode, input int g);
    int e;
    e = WTCLK + FILTSE0 + 2;
    if (mode == 1 && g >= WTCLK + 2 && g < e) e = g + FILTSE0 + 1;
    if (mode == 2 || e > UCHWIN + 1) e = UCHWIN + 1;
    return e;
  endfunction

  // R6 / R7: full-speed context, line lv held until edge d sees K.
  task automatic fs_case(input logic [2:0] lv, input int d);
    int lim, ek, ee;
    logic [3:0] p, pv, ev;
    lim = (lv == L_SE0) ? WTRSTFS : FSSUSP;
    ek = -1; pv = '0;
    neutral();
    ctx = C_FS; line = lv;
    for (int k = 0; k <= lim + d + 4 && ek < 0; k++) begin
      step(p);
      if (p != 0) begin ek = k; pv = p; end
      if (k + 1 == d) line = L_K;
    end
    ee = fs_edge(lim, d);
    ev = (d >= lim + 2) ? ((lv == L_SE0) ? P_HSK : P_SUSP) : P_ABT;
    chk((d >= lim + 2) ? "R6" : "R7", "fs edge", ek, ee);
    chk((d >= lim + 2) ? "R6" : "R7", "fs pulse", int'(pv), int'(ev));
  endtask

  // R8 / R9: high-speed context, hs_idle dropped before edge d, final line fl.
  task automatic hs_case(input int d, input logic [2:0] fl);
    int ek, ee;
    logic [3:0] p, pv, ev;
    ek = -1; pv = '0;
    neutral();
    ctx = C_HS; hs_idle = 1'b1; line = L_SE0;
    for (int k = 0; k <= WTREV + WTRSTHS + 6 && ek < 0; k++) begin
      step(p);
      if (p != 0) begin ek = k; pv = p; end
      if (k == 0) begin
        chk("R8", "hs_term at edge 0", int'(hs_term_en), 1);
        chk("R8", "pullup at edge 0", int'(dp_pullup_en), 0);
      end
      if (d >= WTREV + 2 && k == WTREV)
        chk("R8", "hs_term before fallback", int'(hs_term_en), 1);
      if (d >= WTREV + 2 && k == WTREV + 1) begin
        chk("R8", "hs_term after fallback", int'(hs_term_en), 0);
        chk("R8", "pullup after fallback", int'(dp_pullup_en), 1);
      end
      if (k + 1 == d) hs_idle = 1'b0;
      if (k + 1 == WTREV + 2) line = fl;
    end
    if (d >= WTREV + 2) begin
      ee = WTREV + WTRSTHS + 2;
      ev = (fl == L_SE0) ? P_HSK : P_SUSP;
    end else begin
      ee = d; ev = P_ABT;
    end
    chk((d >= WTREV + 2) ? "R9" : "R8", "hs edge", ek, ee);
    chk((d >= WTREV + 2) ? "R9" : "R8", "hs pulse", int'(pv), int'(ev));
  endtask

  // R4 / R5: suspended context, mode 0 steady SE0, 1 one gap at edge g, 2 gap every 3rd edge.
  task automatic susp_case(input int mode, input int g);
    int ek, ee;
    logic [3:0] p, pv, ev;
    ek = -1; pv = '0;
    neutral();
    ctx = C_SUSP; line = L_SE0;
    for (int k = 0; k <= UCHWIN + 4 && ek < 0; k++) begin
      step(p);
      if (p != 0) begin ek = k; pv = p; end
      line = L_SE0;
      if (mode == 1 && k + 1 == g) line = L_J;
      if (mode == 2 && (k + 1) % 3 == 0) line = L_J;
    end
    ee = susp_edge(mode, g);
    ev = (ee == UCHWIN + 1) ? P_SUSP : P_HSK;
    chk((ee == UCHWIN + 1) ? "R5" : "R4", "susp edge", ek, ee);
    chk((ee == UCHWIN + 1) ? "R5" : "R4", "susp pulse", int'(pv), int'(ev));
  endtask

  // R10: after an outcome the line is ignored and t0 keeps counting.
  task automatic park_case(input logic [2:0] lv, input int lim, input logic [3:0] ev);
    int n, ek;
    logic [3:0] p;
    n = 0; ek = -1;
    neutral();
    ctx = C_FS; line = lv;
    for (int k = 0; k <= 45; k++) begin
      step(p);
      if (p != 0) begin n++; if (ek < 0) ek = k; end
      if (k == lim + 4) line = L_K;
      if (k == lim + 8) line = L_SE0;
      if (k == 40) chk("R10", "t0 while parked", int'(t0_count), 40);
    end
    chk("R10", "outcome edge", ek, lim + 1);
    chk("R10", "pulse count", n, 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      failures++;
      checks++;
      $display("FAIL watchdog (all R) actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [3:0] p;
    int n;
    logic [2:0] lsel;
    void'($urandom(32'd5150));

    repeat (3) @(negedge clk);
    chk("R1", "hs_term in reset", int'(hs_term_en), 0);
    chk("R1", "pullup in reset", int'(dp_pullup_en), 1);
    rst_n = 1'b1;
    step(p);
    chk("R1", "pulses after reset", int'(p), 0);
    chk("R1", "t0 after reset", int'(t0_count), 0);
    chk("R1", "pullup after reset", int'(dp_pullup_en), 1);

    // R11: no context, SE0 ignored
    ctx = C_NONE; line = L_SE0; n = 0;
    for (int k = 0; k < 12; k++) begin step(p); if (p != 0) n++; end
    chk("R11", "pulses with no context", n, 0);
    chk("R11", "t0 with no context", int'(t0_count), 0);

    // R3: K resumes at edge 0, J ignored
    neutral();
    ctx = C_SUSP; line = L_K;
    step(p);
    chk("R3", "resume at edge 0", int'(p), int'(P_RES));
    neutral();
    ctx = C_SUSP; line = L_J; n = 0;
    for (int k = 0; k < 40; k++) begin step(p); if (p != 0) n++; end
    chk("R3", "J while suspended pulses", n, 0);
    chk("R3", "J while suspended t0", int'(t0_count), 0);

    // R4 / R5 directed
    susp_case(0, 0);
    susp_case(1, 3);
    susp_case(1, 10);
    susp_case(1, WTCLK + FILTSE0 + 2);
    susp_case(2, 0);

    // R6 / R7 directed boundaries
    fs_case(L_J, FSSUSP + 2);
    fs_case(L_J, FSSUSP + 1);
    fs_case(L_SE0, WTRSTFS + 2);
    fs_case(L_SE0, 1);

    // R8 / R9 directed
    hs_case(WTREV + 1, L_SE0);
    hs_case(WTREV + 2, L_SE0);
    hs_case(WTREV + 3, L_J);
    hs_case(WTREV + 30, L_K);

    // R10
    park_case(L_SE0, WTRSTFS, P_HSK);
    park_case(L_J, FSSUSP, P_SUSP);

    // Constrained random
    for (int i = 0; i < 24; i++) begin
      lsel = ($urandom() % 2 == 0) ? L_SE0 : L_J;
      fs_case(lsel, 1 + int'($urandom() % ((lsel == L_SE0) ? WTRSTFS + 6 : FSSUSP + 6)));
    end
    for (int i = 0; i < 12; i++) begin
      n = int'($urandom() % 3);
      lsel = (n == 0) ? L_SE0 : ((n == 1) ? L_J : L_K);
      hs_case(1 + int'($urandom() % (WTREV + 6)), lsel);
    end
    for (int i = 0; i < 8; i++) susp_case(1, 1 + int'($urandom() % 20));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule